// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit linear address into a physical address by fetching two 32-bit descriptors from memory. The top ten address bits pick a word in a directory page whose 4 KB frame comes from a base input. The next ten bits pick a word in the page-table page that the directory word names. The low twelve bits pass straight through as the offset inside the final 4 KB frame. Along the way it checks presence, write permission and user permission, and it raises one of two fault kinds when a check fails.

A successful walk marks the touched descriptors as used. The directory word and the table word both get their accessed flag set. A write also sets the dirty flag of the table word. Each of these updates costs one memory write, and only when the flag is still clear. The walker handles one request at a time. It has a single-outstanding memory port whose latency may vary, and a response port that holds its result until the consumer takes it.

Top module: `pt_walker`

## Requirements
- R1: The first memory access of a walk is a read at address {dir_base_pfn, lin[31:22], 2'b00}.
- R2: When the directory word has bit 0 (present) set, the second access is a read at {dir_word[31:12], lin[21:12], 2'b00}.
- R3: A directory word with bit 0 clear ends the walk with fault code 1. The table is not read, memory is not written, and rsp_phys_addr is zero.
- R4: A table word with bit 0 clear ends the walk with fault code 1, with no memory write and a zero physical address.
- R5: When both words are present, a write request ends with fault code 2 unless bit 1 (writable) is set in both words. No write to memory takes place. Code 3 is never produced.
- R6: When both words are present, a user request (req_user=1) ends with fault code 2 unless bit 2 (user) is set in both words. A supervisor request ignores bit 2 at both levels.
- R7: A walk that passes every check responds with fault code 0 and physical address {table_word[31:12], lin[11:0]}.
- R8: After a successful walk, the directory word has bit 5 (accessed) set and all other bits unchanged. It is written back only if bit 5 was clear.
- R9: After a successful walk, the table word has bit 5 set, and bit 6 (dirty) set when the request was a write. All other bits are unchanged. A read never sets bit 6. The word is written back only if its value changes. Bit 6 of the directory word is never modified.
- R10: req_ready is high only while idle. A response, once valid, keeps its address and fault code until it is accepted with rsp_ready.
- R11: Only one memory access is outstanding at a time. Its address, direction and data stay fixed until mem_done. When both write-backs occur, the directory write comes first.
- R12: While reset is asserted and right after it, req_ready=1, rsp_valid=0 and mem_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_lin_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| dir_base_pfn | input | 20 | Frame number of the directory page, latched at acceptance |
| mem_valid | output | 1 | Memory access requested |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data (zero for reads) |
| mem_done | input | 1 | One-cycle pulse that completes the access |
| mem_rdata | input | 32 | Read data, valid with mem_done |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_phys_addr | output | 32 | Translated address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
The assertions assume that the memory answers each access with exactly one mem_done pulse while mem_valid is high, and never pulses mem_done otherwise. The bench's memory responder follows this rule and adds a random wait of zero to three cycles before each pulse. The assertions also assume that the consumer may hold rsp_ready low for any number of cycles. The bench delays acceptance by zero to two cycles and raises req_valid only while the walker is idle. Descriptor words are drawn at random, with presence weighted towards set so that most walks reach the permission and update stages. Directed cases cover every fault path, the supervisor exemption, and the already-marked entries that need no write.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int ADDR_W  = 32;
    localparam int DIR_W   = 10;
    localparam int TBL_W   = 10;
    localparam int OFF_W   = 12;
    localparam int PFN_W   = ADDR_W - OFF_W;
    localparam int IDX_PAD = OFF_W - DIR_W;

    // descriptor flag positions
    localparam int F_PRESENT = 0;
    localparam int F_WRITE   = 1;
    localparam int F_USER    = 2;
    localparam int F_ACC     = 5;
    localparam int F_DIRTY   = 6;

    typedef logic [ADDR_W-1:0] word_t;
    typedef logic [PFN_W-1:0]  pfn_t;

    typedef struct packed {
        logic [DIR_W-1:0] dir;
        logic [TBL_W-1:0] tbl;
        logic [OFF_W-1:0] off;
    } lin_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_WR_DIR,
        ST_WR_TBL,
        ST_RESP
    } walk_st_e;

    function automatic word_t slot_addr(input pfn_t frame, input logic [DIR_W-1:0] idx);
        return {frame, idx, {IDX_PAD{1'b0}}};
    endfunction

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
    import pt_walker_pkg::*;
(
    input  pfn_t  dir_frame,
    input  pfn_t  tbl_frame,
    input  lin_t  lin,
    output word_t dir_addr,
    output word_t tbl_addr,
    output word_t phys_addr,
    input  pfn_t  page_frame
);
    always_comb begin
        dir_addr  = slot_addr(dir_frame, lin.dir);
        tbl_addr  = slot_addr(tbl_frame, lin.tbl);
        phys_addr = {page_frame, lin.off};
    end
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
    import pt_walker_pkg::*;
(
    input  word_t  dir_word,
    input  word_t  tbl_word,
    input  logic   is_write,
    input  logic   is_user,
    output fault_e fault,
    output word_t  dir_new,
    output logic   dir_upd,
    output word_t  tbl_new,
    output logic   tbl_upd
);
    logic both_w;
    logic both_u;

    always_comb begin
        both_w = dir_word[F_WRITE] & tbl_word[F_WRITE];
        both_u = dir_word[F_USER]  & tbl_word[F_USER];

        if (!dir_word[F_PRESENT] || !tbl_word[F_PRESENT])
            fault = FLT_ABSENT;
        else if ((is_write && !both_w) || (is_user && !both_u))
            fault = FLT_PROT;
        else
            fault = FLT_NONE;

        dir_new = dir_word;
        dir_new[F_ACC] = 1'b1;
        dir_upd = !dir_word[F_ACC];

        tbl_new = tbl_word;
        tbl_new[F_ACC] = 1'b1;
        if (is_write)
            tbl_new[F_DIRTY] = 1'b1;
        tbl_upd = (tbl_new != tbl_word);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_lin_addr,
    input  logic        req_write,
    input  logic        req_user,
    input  logic [19:0] dir_base_pfn,
    output logic        mem_valid,
    output logic        mem_write,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_done,
    input  logic [31:0] mem_rdata,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_phys_addr,
    output logic [1:0]  rsp_fault
);
    walk_st_e state;
    lin_t     lin_q;
    pfn_t     base_q;
    logic     wr_q;
    logic     usr_q;
    word_t    dir_q;
    word_t    tbl_q;
    fault_e   fault_q;
    word_t    pa_q;

    word_t    tbl_src;
    word_t    dir_addr;
    word_t    tbl_addr;
    word_t    phys;
    fault_e   chk_fault;
    word_t    dir_new;
    word_t    tbl_new;
    logic     dir_upd;
    logic     tbl_upd;

    // table word comes straight from memory in the cycle it arrives
    assign tbl_src = (state == ST_RD_TBL) ? mem_rdata : tbl_q;

    pt_addr_gen u_addr (
        .dir_frame  (base_q),
        .tbl_frame  (dir_q[ADDR_W-1:OFF_W]),
        .lin        (lin_q),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr),
        .phys_addr  (phys),
        .page_frame (tbl_src[ADDR_W-1:OFF_W])
    );

    pt_perm_check u_perm (
        .dir_word (dir_q),
        .tbl_word (tbl_src),
        .is_write (wr_q),
        .is_user  (usr_q),
        .fault    (chk_fault),
        .dir_new  (dir_new),
        .dir_upd  (dir_upd),
        .tbl_new  (tbl_new),
        .tbl_upd  (tbl_upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            lin_q   <= '0;
            base_q  <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            dir_q   <= '0;
            tbl_q   <= '0;
            fault_q <= FLT_NONE;
            pa_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lin_q  <= lin_t'(req_lin_addr);
                        base_q <= dir_base_pfn;
                        wr_q   <= req_write;
                        usr_q  <= req_user;
                        state  <= ST_RD_DIR;
                    end
                end
                ST_RD_DIR: begin
                    if (mem_done) begin
                        dir_q <= mem_rdata;
                        if (!mem_rdata[F_PRESENT]) begin
                            fault_q <= FLT_ABSENT;
                            pa_q    <= '0;
                            state   <= ST_RESP;
                        end else begin
                            state   <= ST_RD_TBL;
                        end
                    end
                end
                ST_RD_TBL: begin
                    if (mem_done) begin
                        tbl_q   <= mem_rdata;
                        fault_q <= chk_fault;
                        if (chk_fault != FLT_NONE) begin
                            pa_q  <= '0;
                            state <= ST_RESP;
                        end else begin
                            pa_q <= phys;
                            if (dir_upd)
                                state <= ST_WR_DIR;
                            else if (tbl_upd)
                                state <= ST_WR_TBL;
                            else
                                state <= ST_RESP;
                        end
                    end
                end
                ST_WR_DIR: begin
                    if (mem_done)
                        state <= tbl_upd ? ST_WR_TBL : ST_RESP;
                end
                ST_WR_TBL: begin
                    if (mem_done)
                        state <= ST_RESP;
                end
                ST_RESP: begin
                    if (rsp_ready)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready     = (state == ST_IDLE);
        rsp_valid     = (state == ST_RESP);
        rsp_phys_addr = pa_q;
        rsp_fault     = fault_q;
        mem_valid     = 1'b0;
        mem_write     = 1'b0;
        mem_addr      = '0;
        mem_wdata     = '0;
        case (state)
            ST_RD_DIR: begin
                mem_valid = 1'b1;
                mem_addr  = dir_addr;
            end
            ST_RD_TBL: begin
                mem_valid = 1'b1;
                mem_addr  = tbl_addr;
            end
            ST_WR_DIR: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = dir_new;
            end
            ST_WR_TBL: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = tbl_new;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walker_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        mem_valid,
    input logic        mem_write,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_done,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_phys_addr,
    input logic [1:0]  rsp_fault
);
    AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_valid && !rsp_valid)); // R10

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_phys_addr) && $stable(rsp_fault))); // R10

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_done) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata))); // R11

    AST_NO_MEM_IN_RESP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_valid); // R11

    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault != 2'd3)); // R5

    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_phys_addr == 32'd0)); // R3

    AST_WB_MARKS_ACC: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write) |-> (mem_wdata[F_PRESENT] && mem_wdata[F_ACC])); // R8
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .mem_valid     (mem_valid),
    .mem_write     (mem_write),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_done      (mem_done),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_phys_addr (rsp_phys_addr),
    .rsp_fault     (rsp_fault)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin_addr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [19:0] dir_base_pfn = 20'h00100;
    logic        mem_valid;
    logic        mem_write;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_done = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_phys_addr;
    logic [1:0]  rsp_fault;

    localparam logic [19:0] DIR_PFN = 20'h00100;

    logic [31:0] mem [logic [31:0]];
    int          n_chk = 0;
    int          n_err = 0;
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_log0, rd_log1, wr_first;

    always #5 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin_addr(req_lin_addr),
        .req_write(req_write), .req_user(req_user), .dir_base_pfn(dir_base_pfn),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_phys_addr(rsp_phys_addr), .rsp_fault(rsp_fault)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // memory model: one access at a time, random wait, single-cycle done pulse
    initial begin
        int wait_c;
        wait_c = 0;
        forever begin
            @(negedge clk);
            if (mem_done) begin
                mem_done = 1'b0;
            end else if (mem_valid && !rst) begin
                if (wait_c > 0) begin
                    wait_c--;
                end else begin
                    if (mem_write) begin
                        mem[mem_addr] = mem_wdata;
                        if (wr_cnt == 0) wr_first = mem_addr;
                        wr_cnt++;
                    end else begin
                        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                        if (rd_cnt == 0) rd_log0 = mem_addr;
                        if (rd_cnt == 1) rd_log1 = mem_addr;
                        rd_cnt++;
                    end
                    mem_done = 1'b1;
                    wait_c = $urandom_range(0, 3);
                end
            end
        end
    end

    task automatic walk(input string tag, input logic [31:0] lin, input logic wr,
                        input logic usr, input logic [31:0] pde, input logic [31:0] pte,
                        input int hold);
        logic [31:0] pde_a, pte_a, exp_pa, exp_pde, exp_pte, cap_pa;
        logic [1:0]  exp_f, cap_f;
        int          exp_w;
        pde_a = {DIR_PFN, lin[31:22], 2'b00};
        pte_a = {pde[31:12], lin[21:12], 2'b00};
        mem[pde_a] = pde;
        if (pde[0]) mem[pte_a] = pte;
        exp_pde = pde;
        exp_pte = pte;
        exp_pa  = 32'h0;
        exp_w   = 0;
        if (!pde[0] || !pte[0])
            exp_f = 2'd1;
        else if ((wr && !(pde[1] && pte[1])) || (usr && !(pde[2] && pte[2])))
            exp_f = 2'd2;
        else begin
            exp_f   = 2'd0;
            exp_pa  = {pte[31:12], lin[11:0]};
            exp_pde = pde | 32'h20;
            exp_pte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
            exp_w   = int'(exp_pde != pde) + int'(exp_pte != pte);
        end
        wr_cnt = 0;
        rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_lin_addr = lin; req_write = wr; req_user = usr;
        dir_base_pfn = DIR_PFN;
        @(negedge clk);
        req_valid = 1'b0;
        dir_base_pfn = 20'hFFFFF; // latched at acceptance, later value ignored
        while (!rsp_valid) @(negedge clk);
        cap_pa = rsp_phys_addr;
        cap_f  = rsp_fault;
        repeat (hold) @(negedge clk);
        chk("R10", "rsp still valid", {31'd0, rsp_valid}, 32'd1);
        chk("R10", "pa held", rsp_phys_addr, cap_pa);
        chk("R10", "fault held", {30'd0, rsp_fault}, {30'd0, cap_f});
        chk(tag, "fault code", {30'd0, rsp_fault}, {30'd0, exp_f});
        chk(tag, "phys addr", rsp_phys_addr, exp_pa);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R10", "idle after accept", {30'd0, rsp_valid, req_ready}, 32'd1);
        chk("R1", "dir read addr", rd_log0, pde_a);
        chk("R3", "read count", rd_cnt, pde[0] ? 2 : 1);
        if (pde[0]) chk("R2", "table read addr", rd_log1, pte_a);
        chk("R8", "dir word after", mem[pde_a], exp_pde);
        if (pde[0]) chk("R9", "table word after", mem[pte_a], exp_pte);
        chk("R9", "write count", wr_cnt, exp_w);
        if (exp_w == 2) chk("R11", "dir written first", wr_first, pde_a);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R12", "reset outputs", {29'd0, req_ready, rsp_valid, mem_valid}, 32'd4);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "after reset", {29'd0, req_ready, rsp_valid, mem_valid}, 32'd4);

        walk("R3", 32'h0040_3123, 1'b0, 1'b0, 32'h0000_0000, 32'h0,        1);
        walk("R4", 32'h0080_5456, 1'b0, 1'b0, 32'h0020_0027, 32'h1234_5006, 0);
        walk("R5", 32'h00C0_7001, 1'b1, 1'b0, 32'h0020_1007, 32'hABCD_E005, 2);
        walk("R5", 32'h0100_9002, 1'b1, 1'b0, 32'h0020_2005, 32'hABCD_E007, 0);
        walk("R6", 32'h0140_B003, 1'b0, 1'b1, 32'h0020_3007, 32'h1111_1003, 1);
        walk("R6", 32'h0180_D004, 1'b0, 1'b0, 32'h0020_4001, 32'h2222_2001, 0);
        walk("R9", 32'h01C0_F005, 1'b1, 1'b0, 32'h0020_5027, 32'h3333_3067, 0);
        walk("R9", 32'h0201_1006, 1'b0, 1'b0, 32'h0020_6067, 32'h4444_4007, 2);
        walk("R7", 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0020_7007, 32'hFFFF_F007, 0);
        walk("R9", 32'h0241_3007, 1'b1, 1'b1, 32'h0020_8027, 32'h5555_5027, 1);

        for (int i = 0; i < 300; i++) begin
            logic [31:0] lin, pde, pte;
            logic        wr, usr;
            string       tag;
            lin = $urandom;
            wr  = 1'($urandom);
            usr = 1'($urandom);
            pde = {20'h00200 + 20'($urandom_range(0, 15)), 12'($urandom)};
            pte = $urandom;
            pde[0] = ($urandom_range(0, 3) != 0);
            pte[0] = ($urandom_range(0, 3) != 0);
            if (!pde[0])                          tag = "R3";
            else if (!pte[0])                     tag = "R4";
            else if (wr && !(pde[1] && pte[1]))   tag = "R5";
            else if (usr && !(pde[2] && pte[2]))  tag = "R6";
            else                                  tag = "R7";
            walk(tag, lin, wr, usr, pde, pte, $urandom_range(0, 2));
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule